// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C master from a fast reference clock. It holds two pairs of programmable half-period counts. One pair serves standard mode and the other serves fast mode, and a speed-select input picks the active pair. The block drives an open-drain pull-down enable for SCL and counts reference cycles for each half period. Each half period is the programmed count plus a fixed overhead. The low phase starts counting on the cycle the pull-down is asserted, so the SCL fall time is absorbed inside the low count.

After the block releases SCL, it waits until the line reads high through a two-flop synchroniser before it counts the rest of the high phase. A target that holds SCL low (clock stretching) therefore lengthens the high phase by the time it holds the line. When the block is enabled, SCL first stays released for a start-hold interval before the first pull-down. Two single-cycle strobes tell a byte engine when SDA may change and when SCL has been confirmed high. Start and stop generation, data shifting and the computation of count values are handled elsewhere.

Top module: `scl_timebase`

## Requirements
- R1: While reset is applied, and afterwards while `enable` is low, `scl_oe`, `drive_pt` and `sample_pt` are all 0.
- R2: Each low phase holds `scl_oe` at 1 for exactly Leff + 1 consecutive reference cycles, where Leff is the effective low count of the active pair.
- R3: When no target stretches the clock (SCL reads high on the cycle after release), each released (high) phase between two low phases lasts exactly Heff + 8 reference cycles, where Heff is the effective high count of the active pair.
- R4: After the first clock edge that samples `enable` high, SCL stays released for Heff + 3 cycles (the start-hold interval), and the first low phase starts after that.
- R5: With `speed_fast` = 0 the standard pair sets the timing. With `speed_fast` = 1 the fast pair sets it.
- R6: A write through `cfg_we`, `cfg_sel` and `cfg_data` reaches a count register only while `enable` is low. The `cfg_sel` encoding is 0 = standard high, 1 = standard low, 2 = fast high, 3 = fast low. A write made while `enable` is high is ignored.
- R7: A high count below 6 acts as 6. A low count below 8 acts as 8.
- R8: The high-phase count does not start until `scl_in` has been seen high through two synchroniser flops. If the line is released s ≥ 2 cycles after the pull-down ends, the released phase lasts Heff + s + 6 cycles.
- R9: `drive_pt` pulses for exactly the first cycle of each low phase. `sample_pt` pulses for the cycle in which the high count starts, which is the 4th released cycle when no target stretches the clock.
- R10: Dropping `enable` releases SCL on the next clock edge and returns the block to its idle state with its counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the SCL generator; low means idle and open to configuration |
| speed_fast | input | 1 | 0 selects the standard pair, 1 selects the fast pair |
| cfg_we | input | 1 | Count register write strobe |
| cfg_sel | input | 2 | Count register select (0 std high, 1 std low, 2 fast high, 3 fast low) |
| cfg_data | input | CNT_W | Count value to write |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | SCL pull-down enable (1 = drive low) |
| drive_pt | output | 1 | Strobe: first cycle of a low phase, SDA may change |
| sample_pt | output | 1 | Strobe: SCL confirmed high, high count starts |

## Verification
The assertions check several rules on every cycle. The counter never passes the limit of its phase. The hold and low counters advance one step per cycle until they reach their limits. The high count never starts while the synchronised line still reads low. Disabling always returns the block to idle. A write while enabled never changes a stored count. Only the bench scenarios can show the measured lengths of the phases in cycles: low length, released length with and without stretching, and the start-hold interval. The same holds for the effect of speed selection, clamping, and the position of the strobes within each phase.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // Phase of the SCL waveform generator
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,
        PH_LOW  = 3'd2,
        PH_WAIT = 3'd3,
        PH_HIGH = 3'd4
    } phase_e;

    // Count register select encoding
    typedef enum logic [1:0] {
        SEL_STD_HI  = 2'd0,
        SEL_STD_LO  = 2'd1,
        SEL_FAST_HI = 2'd2,
        SEL_FAST_LO = 2'd3
    } cfg_sel_e;

    // Fixed cycle overheads added to the programmed counts
    localparam int HI_OVERHEAD   = 8;
    localparam int LO_OVERHEAD   = 1;
    localparam int HOLD_OVERHEAD = 3;
    localparam int SYNC_STAGES   = 2;

    // Minimum effective counts
    localparam int MIN_HI = 6;
    localparam int MIN_LO = 8;

    // Cycles spent in the release-wait phase with no stretching:
    // the synchroniser stages plus the cycle that sees the line high.
    localparam int WAIT_CYCLES = SYNC_STAGES + 1;

    // Raise a count to its floor
    function automatic int unsigned clamp_floor(int unsigned v, int unsigned floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
    import scl_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DEF_SHI = 40,
    parameter int DEF_SLO = 47,
    parameter int DEF_FHI = 6,
    parameter int DEF_FLO = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             speed_fast,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_data,
    output logic [CNT_W-1:0] eff_hi,
    output logic [CNT_W-1:0] eff_lo
);
    logic [CNT_W-1:0] std_hi, std_lo, fast_hi, fast_lo;
    logic [CNT_W-1:0] act_hi, act_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            std_hi  <= CNT_W'(DEF_SHI);
            std_lo  <= CNT_W'(DEF_SLO);
            fast_hi <= CNT_W'(DEF_FHI);
            fast_lo <= CNT_W'(DEF_FLO);
        end else if (cfg_we && !enable) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_STD_HI:  std_hi  <= cfg_data;
                SEL_STD_LO:  std_lo  <= cfg_data;
                SEL_FAST_HI: fast_hi <= cfg_data;
                default:     fast_lo <= cfg_data;
            endcase
        end
    end

    always_comb begin
        act_hi = speed_fast ? fast_hi : std_hi;
        act_lo = speed_fast ? fast_lo : std_lo;
        eff_hi = CNT_W'(clamp_floor(32'(act_hi), MIN_HI));
        eff_lo = CNT_W'(clamp_floor(32'(act_lo), MIN_LO));
    end

    // R6: stored counts never move while the generator runs
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable({std_hi, std_lo, fast_hi, fast_lo}));

endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_hi
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_hi = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] eff_hi,
    input  logic [CNT_W-1:0] eff_lo,
    input  logic             line_hi,
    output logic             scl_oe,
    output logic             drive_pt,
    output logic             sample_pt
);
    localparam int CW = CNT_W + 1;
    localparam int HIGH_TAIL = HI_OVERHEAD - WAIT_CYCLES - 1;

    phase_e        state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hold_lim, low_lim, high_lim;

    always_comb begin
        hold_lim = CW'(eff_hi) + CW'(HOLD_OVERHEAD - 1);
        low_lim  = CW'(eff_lo) + CW'(LO_OVERHEAD - 1);
        high_lim = CW'(eff_hi) + CW'(HIGH_TAIL);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PH_IDLE: begin
                    state <= PH_HOLD;
                    cnt   <= '0;
                end
                PH_HOLD: begin
                    if (cnt == hold_lim) begin
                        state <= PH_LOW;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_LOW: begin
                    if (cnt == low_lim) begin
                        state <= PH_WAIT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_WAIT: begin
                    if (line_hi) begin
                        state <= PH_HIGH;
                        cnt   <= '0;
                    end
                end
                PH_HIGH: begin
                    if (cnt == high_lim) begin
                        state <= PH_LOW;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    state <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign scl_oe    = (state == PH_LOW);
    assign drive_pt  = (state == PH_LOW)  && (cnt == '0);
    assign sample_pt = (state == PH_HIGH) && (cnt == '0);

    // R2: low counter stays within its limit and steps by one
    assert_low_bound_R2: assert property (@(posedge clk) disable iff (rst)
        state == PH_LOW |-> cnt <= low_lim);
    assert_low_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW && cnt < low_lim && enable) |=> (state == PH_LOW && cnt == $past(cnt) + 1'b1));
    // R3: high counter stays within its limit
    assert_high_bound_R3: assert property (@(posedge clk) disable iff (rst)
        state == PH_HIGH |-> cnt <= high_lim);
    // R4: start-hold stays put until its limit
    assert_hold_stay_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HOLD && cnt != hold_lim && enable) |=> state == PH_HOLD);
    // R8: high count never starts while the synchronised line reads low
    assert_wait_sync_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WAIT && !line_hi) |=> state != PH_HIGH);
    // R9: drive strobe only on entry into a low phase
    assert_drive_entry_R9: assert property (@(posedge clk) disable iff (rst)
        drive_pt |-> $past(state) != PH_LOW);
    // R10: disabling returns to idle with a cleared counter
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == PH_IDLE && cnt == '0));

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase
    import scl_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DEF_SHI = 40,
    parameter int DEF_SLO = 47,
    parameter int DEF_FHI = 6,
    parameter int DEF_FLO = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             speed_fast,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             drive_pt,
    output logic             sample_pt
);
    logic [CNT_W-1:0] eff_hi, eff_lo;
    logic             line_hi;

    scl_cnt_regs #(
        .CNT_W(CNT_W), .DEF_SHI(DEF_SHI), .DEF_SLO(DEF_SLO),
        .DEF_FHI(DEF_FHI), .DEF_FLO(DEF_FLO)
    ) u_regs (
        .clk(clk), .rst(rst), .enable(enable), .speed_fast(speed_fast),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .eff_hi(eff_hi), .eff_lo(eff_lo)
    );

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .line_in(scl_in), .line_hi(line_hi)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .enable(enable),
        .eff_hi(eff_hi), .eff_lo(eff_lo), .line_hi(line_hi),
        .scl_oe(scl_oe), .drive_pt(drive_pt), .sample_pt(sample_pt)
    );

    // R1: nothing is driven while disabled
    assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_oe && !drive_pt && !sample_pt));

endmodule

// File: tb/sim_scl_timebase.sv
module sim_scl_timebase;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst, enable, speed_fast, cfg_we;
    logic [1:0] cfg_sel;
    logic [CNT_W-1:0] cfg_data;
    logic stretch;
    logic scl_in, scl_oe, drive_pt, sample_pt;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Open-drain line with pull-up; a target may hold it low
    assign scl_in = !scl_oe && !stretch;

    scl_timebase #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .speed_fast(speed_fast),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .scl_in(scl_in), .scl_oe(scl_oe), .drive_pt(drive_pt), .sample_pt(sample_pt)
    );

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            report();
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = CNT_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Enable and count negedges until the first pull-down (expect H+4)
    task automatic start_and_hold(output int waited);
        @(negedge clk);
        enable = 1'b1;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!scl_oe && waited < 2000);
    endtask

    // Measure one low phase and the following released phase
    task automatic measure(int stretch_s, output int lo, output int hi,
                           output int drv_first, output int smp_idx);
        while (scl_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        drv_first = int'(drive_pt);
        lo = 0;
        while (scl_oe) begin
            lo++;
            if (lo > 1) drv_first = drv_first + 2 * int'(drive_pt);
            if (stretch_s > 0) stretch = 1'b1;
            @(negedge clk);
        end
        hi = 0;
        smp_idx = 0;
        while (!scl_oe && hi < 2000) begin
            hi++;
            if (sample_pt && smp_idx == 0) smp_idx = hi;
            if (stretch_s > 0 && hi == stretch_s - 1) stretch = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic stop_gen;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; enable = 1'b0; speed_fast = 1'b0; cfg_we = 1'b0;
        cfg_sel = '0; cfg_data = '0; stretch = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", int'(scl_oe), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 oe idle", int'(scl_oe), 0);
        chk("R1 strobes idle", int'(drive_pt | sample_pt), 0);
    endtask

    task automatic t_standard;
        int w, lo, hi, d, s;
        wr(0, 10); wr(1, 12);
        speed_fast = 1'b0;
        start_and_hold(w);
        chk("R4 start hold std", w, 10 + 4);
        for (int i = 0; i < 2; i++) begin
            measure(0, lo, hi, d, s);
            chk("R2 low len std", lo, 13);
            chk("R3 high len std", hi, 18);
            chk("R9 drive strobe first only", d, 1);
            chk("R9 sample strobe index", s, 4);
        end
        stop_gen();
    endtask

    task automatic t_fast;
        int w, lo, hi, d, s;
        wr(2, 7); wr(3, 9);
        speed_fast = 1'b1;
        start_and_hold(w);
        chk("R4 start hold fast", w, 7 + 4);
        measure(0, lo, hi, d, s);
        chk("R5 low len fast", lo, 10);
        chk("R5 high len fast", hi, 15);
        // R6: write while enabled is ignored
        wr(2, 30);
        measure(0, lo, hi, d, s);
        chk("R6 high unchanged after enabled write", hi, 15);
        // R10: disable during a low phase releases next edge
        while (!scl_oe) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 released after disable", int'(scl_oe), 0);
        chk("R10 strobes quiet after disable", int'(drive_pt | sample_pt), 0);
        wr(2, 30);
        start_and_hold(w);
        chk("R6 write accepted while disabled", w, 34);
        measure(0, lo, hi, d, s);
        chk("R6 high after accepted write", hi, 38);
        stop_gen();
    endtask

    task automatic t_clamp;
        int w, lo, hi, d, s;
        wr(0, 2); wr(1, 3);
        speed_fast = 1'b0;
        start_and_hold(w);
        chk("R7 hold uses clamped high", w, 6 + 4);
        measure(0, lo, hi, d, s);
        chk("R7 low clamped to 8", lo, 9);
        chk("R7 high clamped to 6", hi, 14);
        stop_gen();
    endtask

    task automatic t_stretch;
        int w, lo, hi, d, s;
        wr(0, 10); wr(1, 12);
        speed_fast = 1'b0;
        start_and_hold(w);
        measure(10, lo, hi, d, s);
        chk("R8 stretched high len", hi, 10 + 10 + 6);
        chk("R8 sample after stretch", s, 12);
        measure(0, lo, hi, d, s);
        chk("R8 unstretched high len", hi, 18);
        stop_gen();
    endtask

    initial begin
        t_reset();
        t_standard();
        t_fast();
        t_clamp();
        t_stretch();
        report();
        $finish;
    end
endmodule